// File: doc/BRIEF.md
# NAND Flash Address Cycle Generator

This block produces the address phase of a NAND flash access. A command sequencer gives it a mode code and a byte offset and pulses a start input. The block then drives the address latch enable together with one write strobe per address byte on the flash data bus. After the last byte it releases the latch enable and waits for the flash ready/busy line to report ready. It then reports completion with a one-cycle done pulse. Command cycles, data transfers and chip enable stay with the sequencer.

The mode code selects which address cycles are sent:
- column cycles only;
- row (page) cycles only;
- column cycles followed by row cycles;
- a spare-area access, which is column and row cycles with a flag in the second column byte that moves the column past the main page area.

Two static configuration inputs are captured when a request is accepted:
- The bus width input decides which bit carries the spare-area flag.
- The device-size input adds a third row cycle for parts larger than 128 MiB.

The number of setup, strobe and hold clocks around each write strobe is set by parameters.

Top module: `nand_addr_gen`

## Requirements
- R1: Mode codes: 1 sends the two column bytes, 2 sends the row bytes, 3 sends the column bytes and then the row bytes, and 7 sends the same bytes as 3 with the spare flag set. Codes 0, 4, 5 and 6 are ignored: no address cycle, no done pulse, and busy stays low.
- R2: The first column byte is offset bits [7:0]. The second column byte carries offset bits [10:8] in bits [2:0], with bits [7:3] zero outside spare mode.
- R3: In spare mode, the second column byte additionally has bit 3 set when the bus-width input is 0 (8-bit bus), or bit 2 set when it is 1 (16-bit bus). The flag is ORed with offset bits [10:8].
- R4: Row bytes are sent in this order: offset bits [18:11], then [26:19], then [34:27]. The third row byte is sent only when the large-device input is 1.
- R5: Each address byte is presented with the latch enable high for SETUP_CLKS cycles before its strobe. The strobe is then high for STROBE_CLKS cycles, followed by HOLD_CLKS cycles with the strobe low. The byte on the bus does not change while the strobe is high.
- R6: The latch enable stays high without a gap from the first byte's setup to the last byte's hold. Its total high time is the byte count times (SETUP_CLKS+STROBE_CLKS+HOLD_CLKS). It falls with the strobe low, and the strobe is never high while the latch enable is low.
- R7: Done is a single-cycle pulse. It is raised in the cycle after ready/busy is first sampled high with the latch enable low. It never comes while the line still reports busy.
- R8: A start pulse during a burst is ignored. The mode, offset, bus width and device size in use are those captured at the accepted start.
- R9: After reset, the latch enable, strobe, busy and done outputs are low and the bus is zero.
- R10: The address byte is driven on bus bits [7:0], and any upper bus bits are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Request pulse from the sequencer |
| mode_i | input | 3 | Address mode code (see R1) |
| ofs_i | input | OFS_W | Byte offset the address bytes are taken from |
| wide_i | input | 1 | 1 = 16-bit flash bus, 0 = 8-bit bus |
| big_i | input | 1 | 1 = device larger than 128 MiB (third row cycle) |
| rdy_i | input | 1 | Flash ready/busy, 1 = ready |
| ale_o | output | 1 | Address latch enable |
| wr_o | output | 1 | Write strobe, active high |
| bus_o | output | BUS_W | Flash data bus carrying the address byte |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The assertions check the following on every cycle:
- the strobe only occurs inside the latch enable window;
- the bus is held steady under the strobe;
- the latch enable falls only with the strobe low;
- done follows a sampled ready, is a single pulse, and the outputs are quiet while idle.

The byte contents and counts per mode can only be shown by the bench's scenarios. The same holds for the position of the spare flag for each bus width, the third row cycle for large devices, the exact setup, strobe and hold lengths, and the capture of the configuration at start under mid-burst disturbance. The bench sweeps every mode code against both bus widths, both device sizes, several offset patterns and several ready delays.

// File: rtl/nand_addr_pkg.sv
package nand_addr_pkg;

  localparam int COL_CYC = 2;
  localparam int ROW_CYC = 3;
  localparam int MAX_CYC = COL_CYC + ROW_CYC;
  localparam int IDX_W   = $clog2(MAX_CYC);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_STRB,
    ST_HOLD,
    ST_WAIT
  } ag_state_e;

  typedef struct packed {
    logic ok;
    logic col;
    logic row;
    logic spare;
  } mode_dec_t;

  // Request code to address-phase selection
  function automatic mode_dec_t decode_mode(input logic [2:0] code);
    mode_dec_t d;
    d = '0;
    case (code)
      3'd1: begin d.ok = 1'b1; d.col = 1'b1; end
      3'd2: begin d.ok = 1'b1; d.row = 1'b1; end
      3'd3: begin d.ok = 1'b1; d.col = 1'b1; d.row = 1'b1; end
      3'd7: begin d.ok = 1'b1; d.col = 1'b1; d.row = 1'b1; d.spare = 1'b1; end
      default: d = '0;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/nand_addr_bytes.sv
module nand_addr_bytes
  import nand_addr_pkg::*;
#(
  parameter int OFS_W = 35
) (
  input  mode_dec_t                     dec,
  input  logic [OFS_W-1:0]              ofs,
  input  logic                          wide,
  input  logic                          big,
  output logic [MAX_CYC-1:0][7:0]       seq,
  output logic [IDX_W-1:0]              last_idx
);

  localparam int ROW_BASE = 11;

  logic [ROW_CYC-1:0][7:0] row_b;
  logic [7:0]              col_lo;
  logic [7:0]              col_hi;
  logic [7:0]              spare_mask;
  logic [IDX_W:0]          n_total;

  for (genvar g = 0; g < ROW_CYC; g++) begin : g_row
    assign row_b[g] = ofs[ROW_BASE + 8*g +: 8];
  end

  assign spare_mask = !dec.spare ? 8'h00 : (wide ? 8'h04 : 8'h08);
  assign col_lo     = ofs[7:0];
  assign col_hi     = {5'b0, ofs[10:8]} | spare_mask;

  always_comb begin
    seq = '0;
    if (dec.col) begin
      seq[0] = col_lo;
      seq[1] = col_hi;
      for (int r = 0; r < ROW_CYC; r++) seq[COL_CYC + r] = row_b[r];
    end else begin
      for (int r = 0; r < ROW_CYC; r++) seq[r] = row_b[r];
    end
  end

  always_comb begin
    n_total = '0;
    if (dec.col) n_total = n_total + (IDX_W+1)'(COL_CYC);
    if (dec.row) n_total = n_total + (big ? (IDX_W+1)'(ROW_CYC) : (IDX_W+1)'(ROW_CYC - 1));
  end

  assign last_idx = (n_total == '0) ? '0 : IDX_W'(n_total - 1'b1);

endmodule

// File: rtl/nand_phase_timer.sv
module nand_phase_timer #(
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] len,
  output logic          last
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)              cnt_q <= '0;
    else if (load)        cnt_q <= len - 1'b1;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign last = (cnt_q == '0);

endmodule

// File: rtl/nand_addr_gen.sv
module nand_addr_gen
  import nand_addr_pkg::*;
#(
  parameter int OFS_W       = 35,
  parameter int BUS_W       = 16,
  parameter int SETUP_CLKS  = 2,
  parameter int STROBE_CLKS = 2,
  parameter int HOLD_CLKS   = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [2:0]       mode_i,
  input  logic [OFS_W-1:0] ofs_i,
  input  logic             wide_i,
  input  logic             big_i,
  input  logic             rdy_i,
  output logic             ale_o,
  output logic             wr_o,
  output logic [BUS_W-1:0] bus_o,
  output logic             busy_o,
  output logic             done_o
);

  localparam int PH_MAX = (SETUP_CLKS > STROBE_CLKS)
                          ? ((SETUP_CLKS > HOLD_CLKS) ? SETUP_CLKS : HOLD_CLKS)
                          : ((STROBE_CLKS > HOLD_CLKS) ? STROBE_CLKS : HOLD_CLKS);
  localparam int TW = $clog2(PH_MAX + 1);

  ag_state_e               st_q, st_nx;
  logic [IDX_W-1:0]        idx_q, idx_nx;
  logic [IDX_W-1:0]        last_q;
  logic [MAX_CYC-1:0][7:0] seq_q;
  logic [MAX_CYC-1:0][7:0] seq_new;
  logic [IDX_W-1:0]        last_new;
  mode_dec_t               dec;
  logic                    accept;
  logic                    tmr_load;
  logic [TW-1:0]           tmr_len;
  logic                    tmr_last;
  logic                    ale_q, wr_q, busy_q, done_q;
  logic [7:0]              byte_q;
  logic [7:0]              byte_nx;
  logic                    in_burst_nx;

  assign dec    = decode_mode(mode_i);
  assign accept = (st_q == ST_IDLE) && start_i && dec.ok;

  nand_addr_bytes #(.OFS_W(OFS_W)) u_bytes (
    .dec      (dec),
    .ofs      (ofs_i),
    .wide     (wide_i),
    .big      (big_i),
    .seq      (seq_new),
    .last_idx (last_new)
  );

  nand_phase_timer #(.CW(TW)) u_timer (
    .clk  (clk),
    .rst  (rst),
    .load (tmr_load),
    .len  (tmr_len),
    .last (tmr_last)
  );

  // Phase sequencing
  always_comb begin
    st_nx    = st_q;
    idx_nx   = idx_q;
    tmr_load = 1'b0;
    tmr_len  = TW'(SETUP_CLKS);
    case (st_q)
      ST_IDLE: begin
        if (accept) begin
          st_nx    = ST_SETUP;
          idx_nx   = '0;
          tmr_load = 1'b1;
          tmr_len  = TW'(SETUP_CLKS);
        end
      end
      ST_SETUP: begin
        if (tmr_last) begin
          st_nx    = ST_STRB;
          tmr_load = 1'b1;
          tmr_len  = TW'(STROBE_CLKS);
        end
      end
      ST_STRB: begin
        if (tmr_last) begin
          st_nx    = ST_HOLD;
          tmr_load = 1'b1;
          tmr_len  = TW'(HOLD_CLKS);
        end
      end
      ST_HOLD: begin
        if (tmr_last) begin
          if (idx_q == last_q) begin
            st_nx = ST_WAIT;
          end else begin
            st_nx    = ST_SETUP;
            idx_nx   = idx_q + 1'b1;
            tmr_load = 1'b1;
            tmr_len  = TW'(SETUP_CLKS);
          end
        end
      end
      ST_WAIT: begin
        if (rdy_i) st_nx = ST_IDLE;
      end
      default: st_nx = ST_IDLE;
    endcase
  end

  assign in_burst_nx = (st_nx == ST_SETUP) || (st_nx == ST_STRB) || (st_nx == ST_HOLD);

  always_comb begin
    byte_nx = 8'h00;
    if (in_burst_nx) byte_nx = (st_q == ST_IDLE) ? seq_new[0] : seq_q[idx_nx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      last_q <= '0;
      seq_q  <= '0;
      ale_q  <= 1'b0;
      wr_q   <= 1'b0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      byte_q <= 8'h00;
    end else begin
      st_q   <= st_nx;
      idx_q  <= idx_nx;
      if (accept) begin
        seq_q  <= seq_new;
        last_q <= last_new;
      end
      ale_q  <= in_burst_nx;
      wr_q   <= (st_nx == ST_STRB);
      busy_q <= (st_nx != ST_IDLE);
      done_q <= (st_q == ST_WAIT) && rdy_i;
      byte_q <= byte_nx;
    end
  end

  assign ale_o  = ale_q;
  assign wr_o   = wr_q;
  assign busy_o = busy_q;
  assign done_o = done_q;

  if (BUS_W > 8) begin : g_wide_bus
    assign bus_o = {{(BUS_W-8){1'b0}}, byte_q};
  end else begin : g_byte_bus
    assign bus_o = byte_q;
  end

endmodule

// File: rtl/nand_addr_gen_chk.sv
module nand_addr_gen_chk #(
  parameter int BUS_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             rdy_i,
  input logic             ale_o,
  input logic             wr_o,
  input logic [BUS_W-1:0] bus_o,
  input logic             busy_o,
  input logic             done_o
);

  assert_strobe_in_ale_R6: assert property (@(posedge clk) disable iff (rst)
    wr_o |-> ale_o);

  assert_ale_release_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(ale_o) |-> (!wr_o && !$past(wr_o)));

  assert_bus_steady_R5: assert property (@(posedge clk) disable iff (rst)
    wr_o |-> $stable(bus_o));

  assert_done_after_ready_R7: assert property (@(posedge clk) disable iff (rst)
    done_o |-> ($past(rdy_i) && !ale_o));

  assert_done_single_R7: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> (!ale_o && !wr_o));

endmodule

bind nand_addr_gen nand_addr_gen_chk #(.BUS_W(BUS_W)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .rdy_i  (rdy_i),
  .ale_o  (ale_o),
  .wr_o   (wr_o),
  .bus_o  (bus_o),
  .busy_o (busy_o),
  .done_o (done_o)
);

// File: tb/nand_addr_gen_test.sv
module nand_addr_gen_test;

  localparam int OFS_W = 35;
  localparam int BUS_W = 16;
  localparam int S = 2;
  localparam int P = 2;
  localparam int H = 1;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             start_i = 1'b0;
  logic [2:0]       mode_i = 3'd0;
  logic [OFS_W-1:0] ofs_i = '0;
  logic             wide_i = 1'b0;
  logic             big_i = 1'b0;
  logic             rdy_i = 1'b1;
  logic             ale_o, wr_o, busy_o, done_o;
  logic [BUS_W-1:0] bus_o;

  int vectors = 0;
  int fails = 0;
  bit all_done = 0;

  always #5 clk = ~clk;

  nand_addr_gen #(
    .OFS_W(OFS_W), .BUS_W(BUS_W),
    .SETUP_CLKS(S), .STROBE_CLKS(P), .HOLD_CLKS(H)
  ) uut (
    .clk(clk), .rst(rst), .start_i(start_i), .mode_i(mode_i), .ofs_i(ofs_i),
    .wide_i(wide_i), .big_i(big_i), .rdy_i(rdy_i),
    .ale_o(ale_o), .wr_o(wr_o), .bus_o(bus_o), .busy_o(busy_o), .done_o(done_o)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // One address request with full monitoring
  task automatic run_txn(input logic [2:0] mode, input logic [OFS_W-1:0] ofs,
                         input bit wide, input bit big, input int dly, input bit disturb);
    bit col, row, spare, fin, fell, rdy_set, prev_a, prev_w;
    int n, nb, pw, lowrun, ale_cnt, wait_cnt, rdy_cyc;
    logic [7:0] exp_b [0:4];
    logic [7:0] got_b [0:4];
    string tag;

    col   = (mode == 3'd1) || (mode == 3'd3) || (mode == 3'd7);
    row   = (mode == 3'd2) || (mode == 3'd3) || (mode == 3'd7);
    spare = (mode == 3'd7);
    n = 0;
    for (int k = 0; k < 5; k++) begin exp_b[k] = 8'h00; got_b[k] = 8'h00; end
    if (col) begin
      exp_b[0] = ofs[7:0];
      exp_b[1] = {5'b0, ofs[10:8]} | (spare ? (wide ? 8'h04 : 8'h08) : 8'h00);
      n = 2;
    end
    if (row) begin
      exp_b[n]   = ofs[18:11];
      exp_b[n+1] = ofs[26:19];
      n = n + 2;
      if (big) begin exp_b[n] = ofs[34:27]; n = n + 1; end
    end

    @(negedge clk);
    start_i = 1'b1; mode_i = mode; ofs_i = ofs; wide_i = wide; big_i = big; rdy_i = 1'b0;
    @(negedge clk);
    start_i = 1'b0;

    if (n == 0) begin
      // R1: unsupported code must produce nothing
      bit quiet = 1;
      rdy_i = 1'b1;
      for (int c = 0; c < 12; c++) begin
        if (ale_o || wr_o || busy_o || done_o) quiet = 0;
        @(negedge clk);
      end
      check(quiet, "R1", $sformatf("ignored mode %0d stays idle", mode), quiet, 1);
      return;
    end

    fin = 0; fell = 0; rdy_set = 0; prev_a = 0; prev_w = 0;
    nb = 0; pw = 0; lowrun = 0; ale_cnt = 0; wait_cnt = 0; rdy_cyc = -10;
    for (int c = 1; c < 400 && !fin; c++) begin
      if (wr_o && !ale_o) check(0, "R6", "strobe outside latch enable", wr_o, 0);
      if (bus_o[BUS_W-1:8] != '0) check(0, "R10", "upper bus bits", bus_o, bus_o[7:0]);
      if (ale_o) ale_cnt++;
      if (wr_o && !prev_w) begin
        if (nb < 5) got_b[nb] = bus_o[7:0];
        if (nb == 0) check(lowrun == S, "R5", "setup before first strobe", lowrun, S);
        else         check(lowrun == H + S, "R5", "hold+setup between strobes", lowrun, H + S);
        nb++;
      end
      if (wr_o) begin pw++; lowrun = 0; end
      if (!wr_o && prev_w) begin
        check(pw == P, "R5", "strobe width", pw, P);
        pw = 0;
      end
      if (ale_o && !wr_o) lowrun++;
      if (prev_a && !ale_o) begin
        check(lowrun == H, "R5", "hold after last strobe", lowrun, H);
        fell = 1;
      end
      if (done_o) begin
        check(rdy_set && (c == rdy_cyc + 1), "R7", "done one cycle after ready",
              c, rdy_cyc + 1);
        fin = 1;
      end
      if (fell && !rdy_set) begin
        if (wait_cnt == dly) begin rdy_i = 1'b1; rdy_set = 1; rdy_cyc = c; end
        else wait_cnt++;
      end
      if (disturb && c == 2) begin
        start_i = 1'b1; mode_i = 3'd2; ofs_i = ~ofs; wide_i = ~wide; big_i = ~big;
      end
      if (disturb && c == 3) start_i = 1'b0;
      prev_a = ale_o; prev_w = wr_o;
      @(negedge clk);
    end

    check(fin, "R7", "done seen", fin, 1);
    check(nb == n, disturb ? "R8" : "R1", $sformatf("byte count mode %0d", mode), nb, n);
    for (int k = 0; k < n && k < 5; k++) begin
      if (col && k < 2) tag = (k == 1 && spare) ? "R3" : "R2";
      else tag = "R4";
      if (disturb) tag = "R8";
      check(got_b[k] == exp_b[k], tag, $sformatf("byte %0d mode %0d w%0d b%0d", k, mode, wide, big),
            got_b[k], exp_b[k]);
    end
    check(ale_cnt == n * (S + P + H), "R6", "latch enable high time", ale_cnt, n * (S + P + H));
    check(!done_o && !busy_o, "R7", "done single pulse then idle", {done_o, busy_o}, 0);
  endtask

  initial begin
    logic [OFS_W-1:0] pats [0:3];
    pats[0] = '0;
    pats[1] = '1;
    pats[2] = 35'h2_AAAA_AAAA;
    pats[3] = 35'h5_0F3C_7A81;

    repeat (3) @(negedge clk);
    // R9: reset state
    check(!ale_o && !wr_o && !busy_o && !done_o && bus_o == '0, "R9", "reset outputs",
          {ale_o, wr_o, busy_o, done_o, bus_o}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(!ale_o && !wr_o && !busy_o && !done_o && bus_o == '0, "R9", "outputs after reset",
          {ale_o, wr_o, busy_o, done_o, bus_o}, 0);

    for (int m = 0; m < 8; m++)
      for (int w = 0; w < 2; w++)
        for (int b = 0; b < 2; b++)
          for (int p = 0; p < 4; p++)
            run_txn(3'(m), pats[p], w[0], b[0], (m + p + w) % 4, 1'b0);

    // R8: start and configuration changes during a burst are ignored
    run_txn(3'd7, pats[3], 1'b0, 1'b1, 2, 1'b1);
    run_txn(3'd3, pats[2], 1'b1, 1'b0, 0, 1'b1);
    run_txn(3'd1, pats[3], 1'b1, 1'b1, 1, 1'b1);

    all_done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!all_done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule